// File: doc/BRIEF.md
# Block-Read Bus Master

This block is the master side of a synchronous 64-bit read bus. A request gives a byte start address, a block size of 4 or 16 words of 32 bits, and a number of blocks. For each block the master drives the address for one bus cycle. It then waits the fixed access latency of the memory and takes the returned data off the bus as 64-bit beats. Before the next address it leaves the required idle gap.

Memory delivers a block in groups of four words, and each group is two beats. The first group of a block is ready 40 cycles after the address. Each later group in the same block comes 4 cycles after the one before it. In a 16-word block, the two send cycles and two idle cycles of one group therefore overlap the fetch of the next group. The block addresses follow each other with no gaps. A cycle counter records how many cycles the whole request has used.

The request side is valid/ready. A request transfers on a cycle where both `req_valid` and `req_ready` are high, and `req_ready` stays low for the whole transfer. The beat output has no back-pressure, because the bus timing is fixed. A consumer must take every beat in the cycle where `beat_valid` is high.

Top module: `blkrd_master`

## Requirements
- R1: `req_ready` is high exactly when no transfer is in progress, and `xfer_busy` is its complement. A request presented while busy has no effect: it raises no error and does not change the addresses or the data of the running transfer.
- R2: In the first cycle after an accepted request, `bus_addr_valid` is high for one cycle with `bus_addr` equal to the request address. `bus_blk_long` is 1 for a 16-word block and 0 for a 4-word block.
- R3: The first beat of every block appears 41 cycles after its address cycle, leaving 40 wait cycles. The two beats of a group are on consecutive cycles.
- R4: In a 16-word block, group g (0 to 3) is sent at offsets 41+4g and 42+4g from the address cycle, so later groups come every 4 cycles.
- R5: The next address cycle follows the last beat of a block after exactly 2 idle cycles. A 4-word block therefore takes 45 cycles and a 16-word block takes 57.
- R6: Each block address after the first is the previous block address plus the block size in bytes: 16 for 4 words, 64 for 16 words.
- R7: `beat_valid` is high only in send cycles, and `beat_data` equals `bus_rd_data` in that cycle. The memory returns the lower-addressed word in bits 31:0. A block yields `req_bsize`/2 beats.
- R8: `blk_done` is a one-cycle pulse in the cycle right after the last beat of every block, and at no other time.
- R9: `cycle_count` is cleared when a valid request is accepted. It counts every busy cycle and holds its value while idle. 64 blocks of 4 words give 2880, and 16 blocks of 16 words give 912.
- R10: `req_bsize` is a 5-bit word count. Values other than 4 and 16, and `req_nblk` equal to 0, are rejected. The rejection raises `req_err` for the one cycle after the handshake, starts no bus activity, and leaves `cycle_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Master idle, able to take a request |
| req_addr | input | 32 | Byte address of the first block |
| req_bsize | input | 5 | Words per block (4 or 16) |
| req_nblk | input | 8 | Number of blocks to read |
| req_err | output | 1 | One-cycle pulse for a rejected request |
| xfer_busy | output | 1 | Transfer in progress |
| bus_addr_valid | output | 1 | Address cycle on the bus |
| bus_addr | output | 32 | Block address driven to memory |
| bus_blk_long | output | 1 | Block is 16 words (else 4) |
| bus_rd_data | input | 64 | Read data returned by memory |
| beat_valid | output | 1 | A data beat is on `beat_data` |
| beat_data | output | 64 | Captured 64-bit beat |
| blk_done | output | 1 | Pulse after the last beat of a block |
| cycle_count | output | 16 | Busy cycles of the latest accepted request |

## Verification
The bench places every beat at its cycle offset from its own address cycle. A master that counted the 40-cycle wait one cycle short, or that spaced later groups by the short latency plus the idle gap, would sample the wrong cycle and return zeros in place of data. Whole-request cycle totals for one block, three blocks and a 256-word read of each size expose a missing or doubled idle gap, because such an error adds up across the blocks. Requests with bad sizes, with a zero block count, or offered in the middle of a transfer check that a design which latched them anyway would show up as an error pulse, a stray address or a reset counter.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } xfer_st_e;
endpackage

// File: rtl/blkrd_phase.sv
// Per-block schedule: address cycle, first-group wait, overlapped group sends
// and trailing idle gap, decoded from one phase counter.
module blkrd_phase #(
  parameter int LAT_FIRST = 40,
  parameter int LAT_NEXT  = 4,
  parameter int BEATS     = 2,
  parameter int IDLE_CYC  = 2,
  parameter int MAX_GRPS  = 4,
  parameter int GRP_W     = $clog2(MAX_GRPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [GRP_W-1:0] grp_cnt,
  output logic             addr_cyc,
  output logic             send,
  output logic             done_cyc,
  output logic             blk_end
);
  localparam int FIRST_BEAT = 1 + LAT_FIRST;
  localparam int PH_MAX     = FIRST_BEAT + MAX_GRPS * LAT_NEXT + BEATS + IDLE_CYC;
  localparam int PH_W       = $clog2(PH_MAX + 1);

  logic [PH_W-1:0] ph;
  int ph_i, g_i, last_beat_i, off_i;

  always_comb begin
    ph_i        = int'(ph);
    g_i         = int'(grp_cnt);
    last_beat_i = FIRST_BEAT + (g_i - 1) * LAT_NEXT + BEATS - 1;
    off_i       = ph_i - FIRST_BEAT;
    addr_cyc    = run && (ph_i == 0);
    send        = run && (ph_i >= FIRST_BEAT) &&
                  ((off_i / LAT_NEXT) < g_i) && ((off_i % LAT_NEXT) < BEATS);
    done_cyc    = run && (ph_i == last_beat_i + 1);
    blk_end     = run && (ph_i == last_beat_i + IDLE_CYC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ph <= '0;
    else if (!run || blk_end)  ph <= '0;
    else                       ph <= ph + 1'b1;
  end

  AST_NO_BEAT_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_cyc |-> !send); // R3
  AST_DONE_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    done_cyc |-> $past(send)); // R8
endmodule

// File: rtl/blkrd_cyccnt.sv
// Request-latency counter: cleared on accept, advances while busy, holds otherwise.
module blkrd_cyccnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clr)   count <= '0;
    else if (run)   count <= count + 1'b1;
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !run) |=> $stable(count)); // R9
endmodule

// File: rtl/blkrd_master.sv
module blkrd_master #(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int BUS_W       = 64,
  parameter int GROUP_WORDS = 4,
  parameter int MAX_GRPS    = 4,
  parameter int LAT_FIRST   = 40,
  parameter int LAT_NEXT    = 4,
  parameter int IDLE_CYC    = 2,
  parameter int NBLK_W      = 8,
  parameter int CNT_W       = 16,
  parameter int BSZ_W       = $clog2(GROUP_WORDS * MAX_GRPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BSZ_W-1:0]  req_bsize,
  input  logic [NBLK_W-1:0] req_nblk,
  output logic              req_err,
  output logic              xfer_busy,
  output logic              bus_addr_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_blk_long,
  input  logic [BUS_W-1:0]  bus_rd_data,
  output logic              beat_valid,
  output logic [BUS_W-1:0]  beat_data,
  output logic              blk_done,
  output logic [CNT_W-1:0]  cycle_count
);
  import blkrd_pkg::*;

  localparam int BEATS       = GROUP_WORDS * WORD_W / BUS_W;
  localparam int GRP_W       = $clog2(MAX_GRPS + 1);
  localparam int SHORT_BYTES = GROUP_WORDS * WORD_W / 8;
  localparam int LONG_BYTES  = SHORT_BYTES * MAX_GRPS;

  xfer_st_e          st;
  logic [ADDR_W-1:0] cur_addr;
  logic [NBLK_W-1:0] blks_left;
  logic              is_long;
  logic              err_q;
  logic              accept, req_ok;
  logic              addr_cyc, send, done_cyc, blk_end;
  logic [GRP_W-1:0]  grp_cnt;

  assign accept = req_valid && (st == ST_IDLE);
  assign req_ok = ((req_bsize == BSZ_W'(GROUP_WORDS)) ||
                   (req_bsize == BSZ_W'(GROUP_WORDS * MAX_GRPS))) &&
                  (req_nblk != '0);
  assign grp_cnt = is_long ? GRP_W'(MAX_GRPS) : GRP_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cur_addr  <= '0;
      blks_left <= '0;
      is_long   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= accept && !req_ok;
      if (accept && req_ok) begin
        st        <= ST_RUN;
        cur_addr  <= req_addr;
        blks_left <= req_nblk;
        is_long   <= (req_bsize == BSZ_W'(GROUP_WORDS * MAX_GRPS));
      end else if (st == ST_RUN && blk_end) begin
        if (blks_left == NBLK_W'(1)) begin
          st <= ST_IDLE;
        end else begin
          blks_left <= blks_left - 1'b1;
          cur_addr  <= cur_addr + (is_long ? ADDR_W'(LONG_BYTES) : ADDR_W'(SHORT_BYTES));
        end
      end
    end
  end

  blkrd_phase #(
    .LAT_FIRST(LAT_FIRST), .LAT_NEXT(LAT_NEXT), .BEATS(BEATS),
    .IDLE_CYC(IDLE_CYC), .MAX_GRPS(MAX_GRPS), .GRP_W(GRP_W)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .run(st == ST_RUN), .grp_cnt(grp_cnt),
    .addr_cyc(addr_cyc), .send(send), .done_cyc(done_cyc), .blk_end(blk_end)
  );

  blkrd_cyccnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(accept && req_ok), .run(st == ST_RUN),
    .count(cycle_count)
  );

  assign req_ready      = (st == ST_IDLE);
  assign xfer_busy      = (st == ST_RUN);
  assign req_err        = err_q;
  assign bus_addr_valid = addr_cyc;
  assign bus_addr       = cur_addr;
  assign bus_blk_long   = is_long;
  assign beat_valid     = send;
  assign beat_data      = bus_rd_data;
  assign blk_done       = done_cyc;

  AST_ADDR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_valid |=> !bus_addr_valid); // R2
  AST_BEAT_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> xfer_busy); // R7
  AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |-> $past(beat_valid)); // R8
  AST_ERR_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !xfer_busy); // R10
endmodule

// File: tb/blkrd_master_bench.sv
module blkrd_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [4:0]  req_bsize = '0;
  logic [7:0]  req_nblk = '0;
  logic        req_err, xfer_busy, bus_addr_valid, bus_blk_long;
  logic [31:0] bus_addr;
  logic [63:0] bus_rd_data, beat_data;
  logic        beat_valid, blk_done;
  logic [15:0] cycle_count;

  always #5 clk = ~clk;

  blkrd_master u_blkrd_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bsize(req_bsize), .req_nblk(req_nblk),
    .req_err(req_err), .xfer_busy(xfer_busy), .bus_addr_valid(bus_addr_valid),
    .bus_addr(bus_addr), .bus_blk_long(bus_blk_long), .bus_rd_data(bus_rd_data),
    .beat_valid(beat_valid), .beat_data(beat_data), .blk_done(blk_done),
    .cycle_count(cycle_count)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Memory timing model: word value = its byte address; group g of a block
  // is on the bus at offsets 41+4g and 42+4g after the address cycle.
  logic [31:0] m_addr = '0;
  int          m_ph = 0;
  logic        m_long = 1'b0;
  int          m_off, m_j;
  always @(posedge clk) begin
    if (bus_addr_valid) begin
      m_addr <= bus_addr; m_long <= bus_blk_long; m_ph <= 1;
    end else begin
      m_ph <= m_ph + 1;
    end
  end
  always_comb begin
    bus_rd_data = '0;
    m_off = m_ph - 41;
    m_j = 0;
    if (m_ph >= 41 && (m_off % 4) < 2 && (m_off / 4) < (m_long ? 4 : 1)) begin
      m_j = 2 * (m_off / 4) + (m_off % 4);
      bus_rd_data = {m_addr + 32'(8 * m_j + 4), m_addr + 32'(8 * m_j)};
    end
  end

  // Monitor: expected addresses, beat offsets, data and done pulses.
  logic [31:0] exp_blk_addr = '0;
  logic [31:0] beat_base = '0;
  int cur_bsize = 4;
  int since_addr = 0;
  int beat_in_blk = 0;
  int beats_seen = 0;
  int blocks_seen = 0;
  bit prev_beat = 1'b0;
  int exp_off;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_addr_valid) begin
        check(bus_addr == exp_blk_addr, "R2/R6 block address", bus_addr, exp_blk_addr);
        check(bus_blk_long == (cur_bsize == 16), "R2 long flag", bus_blk_long, cur_bsize == 16);
        check(prev_beat == 0 && (blocks_seen == 0 || since_addr >= 44), "R5 idle gap",
              since_addr, 44);
        beat_base = exp_blk_addr;
        exp_blk_addr = exp_blk_addr + 32'(cur_bsize * 4);
        since_addr = 0;
        beat_in_blk = 0;
      end else begin
        since_addr++;
      end
      if (blk_done || (prev_beat && beat_in_blk == cur_bsize / 2))
        check(blk_done && prev_beat && beat_in_blk == cur_bsize / 2, "R8 done pulse",
              blk_done, 1);
      if (blk_done) blocks_seen++;
      if (beat_valid) begin
        exp_off = 41 + 4 * (beat_in_blk / 2) + (beat_in_blk % 2);
        check(since_addr == exp_off, "R3/R4 beat timing", since_addr, exp_off);
        check(beat_data == {beat_base + 32'(8 * beat_in_blk + 4), beat_base + 32'(8 * beat_in_blk)},
              "R7 beat data", beat_data,
              {beat_base + 32'(8 * beat_in_blk + 4), beat_base + 32'(8 * beat_in_blk)});
        beat_in_blk++;
        beats_seen++;
      end
      prev_beat = beat_valid;
    end
  end

  // Vector table: address, block size, block count, expected cycles, bad, poke
  localparam int NV = 8;
  localparam int V_ADDR [NV] = '{32'h1000, 32'h0, 32'h200, 32'h400, 32'h10, 32'h80, 32'h300, 32'h500};
  localparam int V_BSZ  [NV] = '{4, 16, 4, 16, 16, 4, 8, 16};
  localparam int V_NBLK [NV] = '{64, 16, 1, 1, 3, 3, 2, 0};
  localparam int V_CYC  [NV] = '{2880, 912, 45, 57, 171, 135, 135, 135};
  localparam int V_BAD  [NV] = '{0, 0, 0, 0, 0, 0, 1, 1};
  localparam int V_POKE [NV] = '{0, 0, 0, 1, 0, 0, 0, 0};

  task automatic run_vec(input int addr, input int bsz, input int nblk, input int cyc,
                         input int bad, input int poke);
    logic [15:0] prev_cnt;
    @(negedge clk);
    prev_cnt = cycle_count;
    req_valid = 1'b1; req_addr = 32'(addr); req_bsize = 5'(bsz); req_nblk = 8'(nblk);
    exp_blk_addr = 32'(addr); cur_bsize = bsz; blocks_seen = 0; beats_seen = 0;
    @(negedge clk);
    req_valid = 1'b0;
    if (bad != 0) begin
      check(req_err == 1'b1, "R10 err pulse", req_err, 1);
      check(!xfer_busy && !bus_addr_valid, "R10 no bus activity", xfer_busy, 0);
      @(negedge clk);
      check(req_err == 1'b0, "R10 err one cycle", req_err, 0);
      check(cycle_count == prev_cnt, "R10 counter kept", cycle_count, prev_cnt);
    end else begin
      check(xfer_busy && !req_ready, "R1 busy after accept", req_ready, 0);
      check(bus_addr_valid == 1'b1, "R2 address cycle", bus_addr_valid, 1);
      if (poke != 0) begin
        req_valid = 1'b1; req_bsize = 5'd7; req_addr = 32'hdead0000;
        for (int k = 0; k < 20; k++) begin
          @(negedge clk);
          check(req_err == 1'b0 && req_ready == 1'b0, "R1 busy request ignored", req_err, 0);
        end
        req_valid = 1'b0;
      end
      while (xfer_busy) @(negedge clk);
      check(cycle_count == 16'(cyc), "R9 total cycles", cycle_count, cyc);
      check(blocks_seen == nblk, "R8 blocks done", blocks_seen, nblk);
      check(beats_seen == nblk * bsz / 2, "R7 beat count", beats_seen, nblk * bsz / 2);
      check(req_ready == 1'b1, "R1 ready when idle", req_ready, 1);
      repeat (3) @(negedge clk);
      check(cycle_count == 16'(cyc), "R9 counter frozen", cycle_count, cyc);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !xfer_busy, "R1 reset idle", req_ready, 1);
    check(cycle_count == 16'd0, "R9 reset count", cycle_count, 0);
    check(!beat_valid && !bus_addr_valid && !blk_done && !req_err, "R7 reset outputs",
          beat_valid, 0);
    for (int v = 0; v < NV; v++)
      run_vec(V_ADDR[v], V_BSZ[v], V_NBLK[v], V_CYC[v], V_BAD[v], V_POKE[v]);
    // Directed: back-to-back short block right after a rejection
    run_vec(32'h40, 4, 2, 90, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule